// File: doc/BRIEF.md
# Fractional Nanosecond Baud Generator

This block makes the oversampling strobe for a UART receiver and transmitter from a fixed functional clock. Software does not program a cycle count. It programs the length of one sampling period in nanoseconds. The upper part of a 32-bit divisor word is whole nanoseconds, and the low byte is a fraction counted in steps of 1/255 ns. The block adds the functional clock period to a phase register on every cycle. It fires a sample strobe each time the phase reaches the programmed period, and it keeps the remainder so that the fractional part is not lost over many ticks.

A separate 32-bit mode word selects 16 or 8 samples per bit. The higher-rate setting, 8 samples per bit, is meant for line rates of 4 Mbit/s and above. The block derives a bit strobe from the sample strobe. A write to either register restarts the timing from zero. Software computes the divisor value from the wanted baud rate.

Top module: `nsfrac_baud_gen`

## Requirements
- R1: After reset the divisor is RST_INT ns plus RST_FRAC/255 ns and the mode is 16x. `sample_tick` and `bit_tick` are low while reset is applied. The k-th sample tick after reset release follows the R2 rule.
- R2: `wdata[31:8]` is the integer period I in ns and `wdata[7:0]` is the fraction F in 1/255 ns. Let T = 255·I + F and S = 255·CLK_NS, where CLK_NS defaults to 16. Counting from the clock edge that accepted the write as cycle 0, the k-th `sample_tick` is high in the cycle after edge ceil(k·T/S), and `sample_tick` is low in every other cycle.
- R3: The fractional remainder carries over from one tick to the next. After N ticks the accumulated position differs from N·T/S by less than one clock.
- R4: Writing the mode word 32'h16C0_0010 selects 16x oversampling. Any other value selects 8x, including the nominal 8x code 32'h08C0_0008.
- R5: `bit_tick` is high only in cycles where `sample_tick` is also high.
- R6: `bit_tick` is high on the 16th, 32nd, ... sample tick after a restart in 16x mode, and on every 8th sample tick in 8x mode.
- R7: A write to either register clears the phase and the sample count. The next sample tick therefore comes a full period after the write, whatever phase the block was at before.
- R8: If the integer part I is less than CLK_NS, `sample_tick` is high on every clock cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock, nominal period CLK_NS ns |
| rst_n | input | 1 | Synchronous reset, active low |
| div_we | input | 1 | Write strobe for the divisor register |
| mode_we | input | 1 | Write strobe for the mode register |
| wdata | input | 32 | Write data for either register |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit strobe, coincides with a sample strobe |

## Verification
A phase register that keeps the wrong remainder does not show at the first tick. It shows as a tick position that slips against ceil(k·T/S) after a few periods, and over a thousand ticks the slip adds up to more than one clock. A sample counter that is off or not cleared puts `bit_tick` on the wrong sample strobe within one bit time after a write. A missing restart moves the very first tick after a write away from its expected cycle.

// File: rtl/nbg_pkg.sv
// Package: shared types and constants for the fractional nanosecond baud generator.
// Assumes a 32-bit mode word; only the exact 16x code selects 16x oversampling.
package nbg_pkg;
    typedef enum logic {
        OSR_X8  = 1'b0,
        OSR_X16 = 1'b1
    } osr_e;

    localparam logic [31:0] MODE_X16_CODE = 32'h16C0_0010;
    localparam logic [31:0] MODE_X8_CODE  = 32'h08C0_0008;
    localparam int          RATIO_X8      = 8;
    localparam int          RATIO_X16     = 16;
endpackage

// File: rtl/nbg_cfg_regs.sv
// Module: holds the divisor fields and the decoded oversampling mode.
// Assumes writes are single-cycle strobes; restart is handled by the consumers.
module nbg_cfg_regs
    import nbg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int FRAC_W   = 8,
    parameter int RST_INT  = 260,
    parameter int RST_FRAC = 128,
    localparam int INT_W   = DATA_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_we,
    input  logic              mode_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [INT_W-1:0]  div_int,
    output logic [FRAC_W-1:0] div_frac,
    output osr_e              osr
);
    // Divisor register: integer ns in the upper field, 1/255 ns fraction below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_int  <= INT_W'(RST_INT);
            div_frac <= FRAC_W'(RST_FRAC);
        end else if (div_we) begin
            div_int  <= wdata[DATA_W-1:FRAC_W];
            div_frac <= wdata[FRAC_W-1:0];
        end
    end

    // Mode register: only the exact 16x code gives 16x, all else is 8x.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osr <= OSR_X16;
        end else if (mode_we) begin
            osr <= (DATA_W'(MODE_X16_CODE) == wdata) ? OSR_X16 : OSR_X8;
        end
    end
endmodule

// File: rtl/nbg_phase_acc.sv
// Module: phase accumulator that emits one sample strobe per programmed period.
// Assumes threshold = INT*FRAC_DEN + FRAC and one clock = CLK_NS*FRAC_DEN units;
// an integer below CLK_NS saturates to one strobe per clock.
module nbg_phase_acc #(
    parameter int INT_W    = 24,
    parameter int FRAC_W   = 8,
    parameter int CLK_NS   = 16,
    parameter int FRAC_DEN = 255,
    localparam int ACC_W   = INT_W + FRAC_W + 1,
    localparam int STEP    = CLK_NS * FRAC_DEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              fire,
    output logic              tick
);
    logic [ACC_W-1:0] phase_q;
    logic [ACC_W-1:0] thresh;
    logic [ACC_W-1:0] sum;
    logic             saturate;
    logic             reach;

    // Threshold, next phase and the fire decision for this cycle.
    always_comb begin
        thresh   = ACC_W'(div_int) * ACC_W'(FRAC_DEN) + ACC_W'(div_frac);
        sum      = phase_q + ACC_W'(STEP);
        saturate = (div_int < INT_W'(CLK_NS));
        reach    = (sum >= thresh);
        fire     = !restart && (saturate || reach);
    end

    // Phase update: keep the remainder after each strobe, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
            tick    <= 1'b0;
        end else if (saturate) begin
            phase_q <= '0;
            tick    <= 1'b1;
        end else if (reach) begin
            phase_q <= sum - thresh;
            tick    <= 1'b1;
        end else begin
            phase_q <= sum;
            tick    <= 1'b0;
        end
    end
endmodule

// File: rtl/nbg_bit_div.sv
// Module: counts sample strobes and marks every 8th or 16th as a bit strobe.
// Assumes fire is the same-cycle decision that produces the registered sample tick.
module nbg_bit_div
    import nbg_pkg::*;
#(
    localparam int CNT_W = $clog2(RATIO_X16)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic fire,
    input  osr_e osr,
    output logic bit_tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Last count value of a bit for the selected ratio.
    always_comb begin
        last = (osr == OSR_X16) ? CNT_W'(RATIO_X16 - 1) : CNT_W'(RATIO_X8 - 1);
    end

    // Sample counter and registered bit strobe, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q    <= '0;
            bit_tick <= 1'b0;
        end else begin
            bit_tick <= fire && (cnt_q == last);
            if (fire) begin
                cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nsfrac_baud_gen.sv
// Module: top of the fractional nanosecond baud generator.
// Assumes clk has nominal period CLK_NS; a write to either register restarts timing.
module nsfrac_baud_gen
    import nbg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int FRAC_W   = 8,
    parameter int CLK_NS   = 16,
    parameter int FRAC_DEN = 255,
    parameter int RST_INT  = 260,
    parameter int RST_FRAC = 128,
    localparam int INT_W   = DATA_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_we,
    input  logic              mode_we,
    input  logic [DATA_W-1:0] wdata,
    output logic              sample_tick,
    output logic              bit_tick
);
    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] div_frac;
    osr_e              osr;
    logic              restart;
    logic              fire;

    // Restart on any register write.
    always_comb begin
        restart = div_we || mode_we;
    end

    nbg_cfg_regs #(
        .DATA_W  (DATA_W),
        .FRAC_W  (FRAC_W),
        .RST_INT (RST_INT),
        .RST_FRAC(RST_FRAC)
    ) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_we  (div_we),
        .mode_we (mode_we),
        .wdata   (wdata),
        .div_int (div_int),
        .div_frac(div_frac),
        .osr     (osr)
    );

    nbg_phase_acc #(
        .INT_W   (INT_W),
        .FRAC_W  (FRAC_W),
        .CLK_NS  (CLK_NS),
        .FRAC_DEN(FRAC_DEN)
    ) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div_int (div_int),
        .div_frac(div_frac),
        .fire    (fire),
        .tick    (sample_tick)
    );

    nbg_bit_div i_bdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .fire    (fire),
        .osr     (osr),
        .bit_tick(bit_tick)
    );
endmodule

// File: rtl/nbg_checker.sv
// Module: property checker for the baud generator, bound to the top.
// Assumes it sees only the top ports and keeps its own shadow of the writes.
module nbg_checker
    import nbg_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FRAC_W  = 8,
    parameter int CLK_NS  = 16,
    parameter int RST_INT = 260
) (
    input logic              clk,
    input logic              rst_n,
    input logic              div_we,
    input logic              mode_we,
    input logic [DATA_W-1:0] wdata,
    input logic              sample_tick,
    input logic              bit_tick
);
    logic [DATA_W-FRAC_W-1:0] int_q;
    logic                     x16_q;
    logic [4:0]               cnt_q;
    logic [4:0]               ratio_m1;

    // Ratio minus one for the shadow mode.
    always_comb begin
        ratio_m1 = x16_q ? 5'(RATIO_X16 - 1) : 5'(RATIO_X8 - 1);
    end

    // Shadow of written integer period and mode, plus observed sample count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q <= (DATA_W-FRAC_W)'(RST_INT);
            x16_q <= 1'b1;
            cnt_q <= '0;
        end else begin
            if (div_we) int_q <= wdata[DATA_W-1:FRAC_W];
            if (mode_we) x16_q <= (wdata == DATA_W'(MODE_X16_CODE));
            if (div_we || mode_we) cnt_q <= '0;
            else if (sample_tick) cnt_q <= (cnt_q == ratio_m1) ? '0 : cnt_q + 5'd1;
        end
    end

    AST_BIT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick); // R5
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (div_we || mode_we) |=> (!sample_tick && !bit_tick)); // R7
    AST_SATURATED_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_we && !mode_we && int_q < (DATA_W-FRAC_W)'(CLK_NS)) |=> sample_tick); // R8
    AST_BIT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> (bit_tick == (cnt_q == ratio_m1))); // R6
endmodule

bind nsfrac_baud_gen nbg_checker #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .CLK_NS (CLK_NS),
    .RST_INT(RST_INT)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_we     (div_we),
    .mode_we    (mode_we),
    .wdata      (wdata),
    .sample_tick(sample_tick),
    .bit_tick   (bit_tick)
);

// File: tb/test_nsfrac_baud_gen.sv
// Bench: directed corners plus seeded random divisors and modes.
module test_nsfrac_baud_gen;
    localparam longint STEP     = 16 * 255;
    localparam logic [31:0] X16 = 32'h16C0_0010;
    localparam logic [31:0] X8  = 32'h08C0_0008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_we = 1'b0;
    logic        mode_we = 1'b0;
    logic [31:0] wdata = '0;
    logic        sample_tick;
    logic        bit_tick;

    int n_checks = 0;
    int n_fail   = 0;
    int ratio    = 16;

    always #5 clk = ~clk;

    nsfrac_baud_gen i_nsfrac_baud_gen (
        .clk(clk), .rst_n(rst_n), .div_we(div_we), .mode_we(mode_we),
        .wdata(wdata), .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    function automatic longint exp_pos(longint k, longint t, bit sat);
        if (sat) return k;
        return (k * t + STEP - 1) / STEP;
    endfunction

    function automatic int ratio_of(logic [31:0] code);
        return (code == X16) ? 16 : 8;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_div(int unsigned ip, int unsigned fp);
        @(negedge clk);
        div_we = 1'b1;
        wdata  = {ip[23:0], fp[7:0]};
        @(posedge clk);
        #1 div_we = 1'b0;
    endtask

    task automatic write_mode(logic [31:0] code);
        @(negedge clk);
        mode_we = 1'b1;
        wdata   = code;
        @(posedge clk);
        #1 mode_we = 1'b0;
        ratio = ratio_of(code);
    endtask

    // Observe ticks from the last restart edge and compare to ceil(k*T/S).
    task automatic run_ticks(int unsigned ip, int unsigned fp, int nticks, string req);
        longint t = longint'(ip) * 255 + fp;
        bit sat = (ip < 16);
        longint limit = longint'(nticks) * (ip / 16 + 2) + 10;
        longint k = 0;
        longint last_n = 0;
        longint bad_pos = -1, bad_act = 0, bad_exp = 0;
        bit bit_ok = 1'b1;
        for (longint n = 1; n <= limit && k < nticks; n++) begin
            @(posedge clk);
            #1;
            if (sample_tick) begin
                k++;
                last_n = n;
                if (bad_pos < 0 && n != exp_pos(k, t, sat)) begin
                    bad_pos = k; bad_act = n; bad_exp = exp_pos(k, t, sat);
                end
                if (bit_tick != ((k % ratio) == 0)) bit_ok = 1'b0;
            end else if (bit_tick) begin
                bit_ok = 1'b0;
            end
        end
        check(k == nticks, req, "tick count", k, nticks);
        check(bad_pos < 0, req, "tick position", bad_act, bad_exp);
        check(bit_ok, (ratio == 16) ? "R6/R4 16x" : "R6/R4 8x", "bit tick placement", bit_ok, 1);
        if (!sat) begin
            longint drift = last_n * STEP - longint'(nticks) * t;
            if (drift < 0) drift = -drift;
            check(drift < STEP, "R3", "accumulated drift", drift, 0);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: outputs low under reset, then defaults 260 + 128/255 ns, 16x.
        repeat (3) @(posedge clk);
        #1;
        check(!sample_tick && !bit_tick, "R1", "outputs in reset", {sample_tick, bit_tick}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        ratio = 16;
        run_ticks(260, 128, 40, "R1");

        // R2/R3: long run, 1000 ticks with a fractional period.
        write_div(100, 77);
        run_ticks(100, 77, 1000, "R2");

        // R4: other code gives 8x, nominal 8x code gives 8x, exact code 16x.
        write_mode(32'h1234_5678);
        run_ticks(100, 77, 48, "R4");
        write_mode(X8);
        run_ticks(100, 77, 48, "R4");
        write_mode(X16);
        run_ticks(100, 77, 48, "R4");

        // R8: saturation below one clock period, and the exact-one-clock boundary.
        write_div(0, 0);
        run_ticks(0, 0, 40, "R8");
        write_div(15, 255);
        run_ticks(15, 255, 40, "R8");
        write_div(16, 0);
        run_ticks(16, 0, 40, "R2");
        write_div(16, 1);
        run_ticks(16, 1, 200, "R2");

        // R7: restart mid-period by a mode write and by a divisor write.
        write_div(500, 200);
        repeat (17) @(posedge clk);
        write_mode(X8);
        run_ticks(500, 200, 20, "R7");
        repeat (9) @(posedge clk);
        write_div(500, 200);
        run_ticks(500, 200, 20, "R7");

        // Random divisors and modes (R2/R6).
        for (int i = 0; i < 8; i++) begin
            int unsigned ip = 16 + ($urandom % 300);
            int unsigned fp = $urandom % 256;
            int unsigned m  = $urandom % 3;
            write_mode((m == 0) ? X16 : ((m == 1) ? X8 : $urandom));
            write_div(ip, fp);
            run_ticks(ip, fp, 50, "R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule